// File: doc/BRIEF.md
# Two-Stage Translation Cache with Granule Retry

This block is a small, fully associative cache of finished address translations for an I/O memory management unit that can run stage 1 only, stage 2 only, or both stages nested. A page-table walker outside the block inserts entries, and each entry already holds the combined result of both stages. An entry is tagged by address-space identifier, virtual-machine identifier, input address aligned to its block size, translation-granule code and table level. It also stores the output block address and one write permission for each stage.

A lookup gives the identifiers, the input address, the access kind, the stage mode and the granule sizes of both stages. The block probes the stored entries level by level, starting with the shallowest level. A combined entry may have been cached with the stage-2 granule. For that reason, a nested lookup that finds nothing with the stage-1 granule makes one more pass with the stage-2 granule when the two granules differ. The one-cycle response pulse reports hit or miss and the output address. For a write that is denied, it also reports a permission fault and the stage that caused it. The block counts hits and misses, and a flush input empties the whole cache.

Top module: `nest_tlb`

## Requirements
- R1: A granule of 2^n bytes has the code (n-10)/2, so log2 sizes 12, 14 and 16 map to codes 1, 2 and 3. An entry can only match a probe whose granule code equals its own.
- R2: An entry matches when it is valid and when its address-space identifier, its virtual-machine identifier and its aligned address all equal those of the probe. The address is aligned by clearing the low s bits, where s = p + (3 - level)*(p - 3) and p = 10 + 2*code. When s is at least the address width, the entry covers the whole address space.
- R3: A probe checks levels from FIRST_LVL (default 0) up to 3 and uses the first level that has a match, so a shallower-level entry wins over a deeper one. When two entries match at the same level, the lower slot index wins.
- R4: On a hit without fault, resp_paddr is the entry's output block address OR the input-address bits below s.
- R5: If the first pass misses, req_mode is 2'b11 (nested) and the stage-2 granule code differs from the stage-1 code, a second pass is made with the stage-2 granule. A lookup accepted at a clock edge raises resp_valid one edge later when it needs one pass and two edges later when it needs two.
- R6: In any other mode (2'b01 stage 1, 2'b10 stage 2), or when the two granule codes are equal, a miss ends after the first pass.
- R7: A read never faults. A write that hits faults unless both the stage-1 and the stage-2 write permissions of the entry are set.
- R8: On a fault, resp_fault_s2 is 0 when the stage-1 write permission is clear, and 1 when only the stage-2 write permission is clear.
- R9: hit_count increments once for each lookup that hits, faulted hits included. miss_count increments once for each lookup that misses. Neither counter changes at any other time, and both are 0 after reset.
- R10: A flush clears every entry in one cycle and takes priority over an insert in the same cycle.
- R11: An insert writes the lowest-numbered invalid slot. When no slot is invalid, it writes the slot named by a round-robin pointer. The pointer starts at 0 and advances, wrapping, only on such a replacement.
- R12: req_ready is high only while no lookup is in progress. resp_valid is a single-cycle pulse. resp_paddr is 0 on a miss or a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| ins_valid | input | 1 | Insert an entry this cycle |
| ins_asid | input | ASID_W | Address-space identifier of the new entry |
| ins_vmid | input | VMID_W | Virtual-machine identifier of the new entry |
| ins_iova | input | ADDR_W | Input address inside the new entry's block |
| ins_gran_log2 | input | 5 | log2 of the granule size the entry was cached with |
| ins_level | input | 2 | Table level of the entry |
| ins_oa | input | ADDR_W | Output address of the block (low bits ignored) |
| ins_s1_wr | input | 1 | Stage-1 write permission |
| ins_s2_wr | input | 1 | Stage-2 write permission |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Ready to accept a lookup |
| req_asid | input | ASID_W | Lookup address-space identifier |
| req_vmid | input | VMID_W | Lookup virtual-machine identifier |
| req_iova | input | ADDR_W | Lookup input address |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_mode | input | 2 | 01 stage 1, 10 stage 2, 11 nested |
| req_s1_gran_log2 | input | 5 | log2 of the stage-1 granule size |
| req_s2_gran_log2 | input | 5 | log2 of the stage-2 granule size |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Lookup found an entry |
| resp_paddr | output | ADDR_W | Translated address |
| resp_fault | output | 1 | Write permission fault |
| resp_fault_s2 | output | 1 | Fault caused by stage 2 (else stage 1) |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |

## Verification
The assertions check on every cycle that the counters step by exactly one only on responses, matching the hit flag, and that a flush leaves no valid slot. They also check that a fault only appears on a write that hit, that a second pass happens only when nesting and differing granules allow it, and that responses are single pulses with a zero address on a miss or a fault. Only the bench scenarios can show that the address arithmetic, the level priority, the granule retry with its extra cycle, the choice of fault stage and the round-robin replacement order give the right values.

// File: rtl/nest_tlb_pkg.sv
package nest_tlb_pkg;

  localparam logic [1:0] MODE_S1   = 2'b01;
  localparam logic [1:0] MODE_S2   = 2'b10;
  localparam logic [1:0] MODE_NEST = 2'b11;

  // granule code from log2 of the granule size
  function automatic logic [1:0] gran_code(input logic [4:0] log2sz);
    logic [4:0] d;
    d = (log2sz - 5'd10) >> 1;
    return d[1:0];
  endfunction

  // number of offset bits covered by an entry of this code and level
  function automatic int unsigned blk_shift(input logic [1:0] code, input logic [1:0] lvl);
    int unsigned pg;
    pg = 10 + 2 * int'(code);
    return pg + (3 - int'(lvl)) * (pg - 3);
  endfunction

  // ones in the offset bits, saturating at 64 bits
  function automatic logic [63:0] blk_mask(input logic [1:0] code, input logic [1:0] lvl);
    int unsigned sh;
    sh = blk_shift(code, lvl);
    if (sh >= 64) return '1;
    return (64'd1 << sh) - 64'd1;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import nest_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  parameter int VMID_W  = 8,
  parameter int ADDR_W  = 40
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              ins_valid,
  input  logic [ASID_W-1:0]                 ins_asid,
  input  logic [VMID_W-1:0]                 ins_vmid,
  input  logic [ADDR_W-1:0]                 ins_iova,
  input  logic [1:0]                        ins_code,
  input  logic [1:0]                        ins_level,
  input  logic [ADDR_W-1:0]                 ins_oa,
  input  logic                              ins_s1_wr,
  input  logic                              ins_s2_wr,
  output logic [ENTRIES-1:0]                ent_valid,
  output logic [ENTRIES-1:0][ASID_W-1:0]    ent_asid,
  output logic [ENTRIES-1:0][VMID_W-1:0]    ent_vmid,
  output logic [ENTRIES-1:0][ADDR_W-1:0]    ent_base,
  output logic [ENTRIES-1:0][1:0]           ent_code,
  output logic [ENTRIES-1:0][1:0]           ent_lvl,
  output logic [ENTRIES-1:0][ADDR_W-1:0]    ent_oa,
  output logic [ENTRIES-1:0]                ent_s1w,
  output logic [ENTRIES-1:0]                ent_s2w
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]  rr_ptr;
  logic [IDX_W-1:0]  free_idx;
  logic              have_free;
  logic [IDX_W-1:0]  victim;
  logic [ADDR_W-1:0] ins_msk;

  // lowest free slot
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign victim  = have_free ? free_idx : rr_ptr;
  assign ins_msk = ADDR_W'(blk_mask(ins_code, ins_level));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_asid  <= '0;
      ent_vmid  <= '0;
      ent_base  <= '0;
      ent_code  <= '0;
      ent_lvl   <= '0;
      ent_oa    <= '0;
      ent_s1w   <= '0;
      ent_s2w   <= '0;
      rr_ptr    <= '0;
    end else if (flush) begin
      ent_valid <= '0;
    end else if (ins_valid) begin
      ent_valid[victim] <= 1'b1;
      ent_asid[victim]  <= ins_asid;
      ent_vmid[victim]  <= ins_vmid;
      ent_base[victim]  <= ins_iova & ~ins_msk;
      ent_code[victim]  <= ins_code;
      ent_lvl[victim]   <= ins_level;
      ent_oa[victim]    <= ins_oa & ~ins_msk;
      ent_s1w[victim]   <= ins_s1_wr;
      ent_s2w[victim]   <= ins_s2_wr;
      if (!have_free) begin
        rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import nest_tlb_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int ASID_W    = 8,
  parameter int VMID_W    = 8,
  parameter int ADDR_W    = 40,
  parameter int FIRST_LVL = 0
) (
  input  logic [ENTRIES-1:0]                ent_valid,
  input  logic [ENTRIES-1:0][ASID_W-1:0]    ent_asid,
  input  logic [ENTRIES-1:0][VMID_W-1:0]    ent_vmid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]    ent_base,
  input  logic [ENTRIES-1:0][1:0]           ent_code,
  input  logic [ENTRIES-1:0][1:0]           ent_lvl,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]    ent_oa,
  input  logic [ENTRIES-1:0]                ent_s1w,
  input  logic [ENTRIES-1:0]                ent_s2w,
  input  logic [ASID_W-1:0]                 p_asid,
  input  logic [VMID_W-1:0]                 p_vmid,
  input  logic [ADDR_W-1:0]                 p_addr,
  input  logic [1:0]                        p_code,
  output logic                              m_hit,
  output logic [ADDR_W-1:0]                 m_paddr,
  output logic                              m_s1w,
  output logic                              m_s2w
);

  logic [ENTRIES-1:0]             match;
  logic [ENTRIES-1:0][ADDR_W-1:0] offs;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [ADDR_W-1:0] msk;
    assign msk = ADDR_W'(blk_mask(ent_code[i], ent_lvl[i]));
    assign match[i] = ent_valid[i]
                   && (ent_asid[i] == p_asid)
                   && (ent_vmid[i] == p_vmid)
                   && (ent_code[i] == p_code)
                   && ((p_addr & ~msk) == ent_base[i]);
    assign offs[i] = p_addr & msk;
  end

  // shallowest level first, then lowest slot
  always_comb begin
    m_hit   = 1'b0;
    m_paddr = '0;
    m_s1w   = 1'b0;
    m_s2w   = 1'b0;
    for (int l = FIRST_LVL; l < 4; l++) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!m_hit && match[i] && (int'(ent_lvl[i]) == l)) begin
          m_hit   = 1'b1;
          m_paddr = ent_oa[i] | offs[i];
          m_s1w   = ent_s1w[i];
          m_s2w   = ent_s2w[i];
        end
      end
    end
  end

endmodule

// File: rtl/tlb_lookup_ctrl.sv
module tlb_lookup_ctrl
  import nest_tlb_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int VMID_W = 8,
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VMID_W-1:0] req_vmid,
  input  logic [ADDR_W-1:0] req_iova,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic [4:0]        req_s1_gran_log2,
  input  logic [4:0]        req_s2_gran_log2,
  output logic [ASID_W-1:0] p_asid,
  output logic [VMID_W-1:0] p_vmid,
  output logic [ADDR_W-1:0] p_addr,
  output logic [1:0]        p_code,
  input  logic              m_hit,
  input  logic [ADDR_W-1:0] m_paddr,
  input  logic              m_s1w,
  input  logic              m_s2w,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic              resp_fault,
  output logic              resp_fault_s2,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic              busy,
  output logic              in_pass2,
  output logic              retry_ok,
  output logic              lat_write
);

  typedef enum logic [1:0] {ST_IDLE, ST_P1, ST_P2} st_e;
  st_e st;

  logic [1:0] l_mode;
  logic [1:0] l_g1, l_g2;
  logic       fin;
  logic       flt;

  assign busy      = (st != ST_IDLE);
  assign in_pass2  = (st == ST_P2);
  assign req_ready = (st == ST_IDLE);
  assign retry_ok  = (l_mode == MODE_NEST) && (l_g1 != l_g2);
  assign p_code    = in_pass2 ? l_g2 : l_g1;
  assign fin       = (st == ST_P2) || ((st == ST_P1) && (m_hit || !retry_ok));
  assign flt       = m_hit && lat_write && !(m_s1w && m_s2w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      p_asid        <= '0;
      p_vmid        <= '0;
      p_addr        <= '0;
      lat_write     <= 1'b0;
      l_mode        <= '0;
      l_g1          <= '0;
      l_g2          <= '0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_paddr    <= '0;
      resp_fault    <= 1'b0;
      resp_fault_s2 <= 1'b0;
      hit_count     <= '0;
      miss_count    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          p_asid    <= req_asid;
          p_vmid    <= req_vmid;
          p_addr    <= req_iova;
          lat_write <= req_write;
          l_mode    <= req_mode;
          l_g1      <= gran_code(req_s1_gran_log2);
          l_g2      <= gran_code(req_s2_gran_log2);
          st        <= ST_P1;
        end
        ST_P1:   st <= fin ? ST_IDLE : ST_P2;
        default: st <= ST_IDLE;
      endcase
      if (fin) begin
        resp_valid    <= 1'b1;
        resp_hit      <= m_hit;
        resp_fault    <= flt;
        resp_fault_s2 <= flt && m_s1w;
        resp_paddr    <= (m_hit && !flt) ? m_paddr : '0;
        if (m_hit) hit_count  <= hit_count + 1'b1;
        else       miss_count <= miss_count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nest_tlb.sv
module nest_tlb
  import nest_tlb_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int ASID_W    = 8,
  parameter int VMID_W    = 8,
  parameter int ADDR_W    = 40,
  parameter int CNT_W     = 16,
  parameter int FIRST_LVL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ins_valid,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic [VMID_W-1:0] ins_vmid,
  input  logic [ADDR_W-1:0] ins_iova,
  input  logic [4:0]        ins_gran_log2,
  input  logic [1:0]        ins_level,
  input  logic [ADDR_W-1:0] ins_oa,
  input  logic              ins_s1_wr,
  input  logic              ins_s2_wr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VMID_W-1:0] req_vmid,
  input  logic [ADDR_W-1:0] req_iova,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic [4:0]        req_s1_gran_log2,
  input  logic [4:0]        req_s2_gran_log2,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic              resp_fault,
  output logic              resp_fault_s2,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  logic [ENTRIES-1:0]             valid_vec;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  logic [ENTRIES-1:0][VMID_W-1:0] ent_vmid;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_base;
  logic [ENTRIES-1:0][1:0]        ent_code;
  logic [ENTRIES-1:0][1:0]        ent_lvl;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_oa;
  logic [ENTRIES-1:0]             ent_s1w;
  logic [ENTRIES-1:0]             ent_s2w;

  logic [ASID_W-1:0] p_asid;
  logic [VMID_W-1:0] p_vmid;
  logic [ADDR_W-1:0] p_addr;
  logic [1:0]        p_code;
  logic              m_hit;
  logic [ADDR_W-1:0] m_paddr;
  logic              m_s1w, m_s2w;
  logic              busy, in_pass2, retry_ok, lat_write;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VMID_W(VMID_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_vmid(ins_vmid),
    .ins_iova(ins_iova), .ins_code(gran_code(ins_gran_log2)), .ins_level(ins_level),
    .ins_oa(ins_oa), .ins_s1_wr(ins_s1_wr), .ins_s2_wr(ins_s2_wr),
    .ent_valid(valid_vec), .ent_asid(ent_asid), .ent_vmid(ent_vmid),
    .ent_base(ent_base), .ent_code(ent_code), .ent_lvl(ent_lvl),
    .ent_oa(ent_oa), .ent_s1w(ent_s1w), .ent_s2w(ent_s2w)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VMID_W(VMID_W), .ADDR_W(ADDR_W),
    .FIRST_LVL(FIRST_LVL)
  ) u_match (
    .ent_valid(valid_vec), .ent_asid(ent_asid), .ent_vmid(ent_vmid),
    .ent_base(ent_base), .ent_code(ent_code), .ent_lvl(ent_lvl),
    .ent_oa(ent_oa), .ent_s1w(ent_s1w), .ent_s2w(ent_s2w),
    .p_asid(p_asid), .p_vmid(p_vmid), .p_addr(p_addr), .p_code(p_code),
    .m_hit(m_hit), .m_paddr(m_paddr), .m_s1w(m_s1w), .m_s2w(m_s2w)
  );

  tlb_lookup_ctrl #(
    .ASID_W(ASID_W), .VMID_W(VMID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_asid(req_asid), .req_vmid(req_vmid), .req_iova(req_iova),
    .req_write(req_write), .req_mode(req_mode),
    .req_s1_gran_log2(req_s1_gran_log2), .req_s2_gran_log2(req_s2_gran_log2),
    .p_asid(p_asid), .p_vmid(p_vmid), .p_addr(p_addr), .p_code(p_code),
    .m_hit(m_hit), .m_paddr(m_paddr), .m_s1w(m_s1w), .m_s2w(m_s2w),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .resp_fault_s2(resp_fault_s2),
    .hit_count(hit_count), .miss_count(miss_count),
    .busy(busy), .in_pass2(in_pass2), .retry_ok(retry_ok), .lat_write(lat_write)
  );

endmodule

// File: rtl/nest_tlb_chk.sv
module nest_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 40,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               ins_valid,
  input logic               resp_valid,
  input logic               resp_hit,
  input logic [ADDR_W-1:0]  resp_paddr,
  input logic               resp_fault,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               busy,
  input logic               in_pass2,
  input logic               retry_ok,
  input logic               lat_write
);

  a_r9_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> hit_count == $past(hit_count) + 1'b1);

  a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> miss_count == $past(miss_count) + 1'b1);

  a_r9_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> $stable(hit_count) && $stable(miss_count));

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0);

  a_r11_insert_fills: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !flush |=> valid_vec != '0);

  a_r7_fault_on_write_hit: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_hit && lat_write);

  a_r6_second_pass_legal: assert property (@(posedge clk) disable iff (!rst_n)
    in_pass2 |-> retry_ok);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r12_resp_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(busy));

  a_r12_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (!resp_hit || resp_fault) |-> resp_paddr == '0);

endmodule

bind nest_tlb nest_tlb_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ins_valid(ins_valid),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
  .resp_fault(resp_fault), .hit_count(hit_count), .miss_count(miss_count),
  .valid_vec(valid_vec), .busy(busy), .in_pass2(in_pass2),
  .retry_ok(retry_ok), .lat_write(lat_write)
);

// File: tb/tb_nest_tlb.sv
module tb_nest_tlb;

  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          ins_valid = 1'b0;
  logic [7:0]    ins_asid = '0, ins_vmid = '0;
  logic [AW-1:0] ins_iova = '0, ins_oa = '0;
  logic [4:0]    ins_gran_log2 = 5'd12;
  logic [1:0]    ins_level = 2'd3;
  logic          ins_s1_wr = 1'b1, ins_s2_wr = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [7:0]    req_asid = '0, req_vmid = '0;
  logic [AW-1:0] req_iova = '0;
  logic          req_write = 1'b0;
  logic [1:0]    req_mode = 2'b01;
  logic [4:0]    req_s1_gran_log2 = 5'd12, req_s2_gran_log2 = 5'd12;
  logic          resp_valid, resp_hit, resp_fault, resp_fault_s2;
  logic [AW-1:0] resp_paddr;
  logic [15:0]   hit_count, miss_count;

  int checks = 0;
  int failures = 0;
  int exp_hits = 0;
  int exp_misses = 0;

  always #4 clk = ~clk;

  nest_tlb dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_vmid(ins_vmid),
    .ins_iova(ins_iova), .ins_gran_log2(ins_gran_log2), .ins_level(ins_level),
    .ins_oa(ins_oa), .ins_s1_wr(ins_s1_wr), .ins_s2_wr(ins_s2_wr),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_asid(req_asid), .req_vmid(req_vmid), .req_iova(req_iova),
    .req_write(req_write), .req_mode(req_mode),
    .req_s1_gran_log2(req_s1_gran_log2), .req_s2_gran_log2(req_s2_gran_log2),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .resp_fault_s2(resp_fault_s2),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic insert(input logic [7:0] asid, input logic [7:0] vmid, input logic [AW-1:0] iova,
                        input logic [4:0] g, input logic [1:0] lvl, input logic [AW-1:0] oa,
                        input logic w1, input logic w2);
    @(negedge clk);
    ins_valid = 1'b1; ins_asid = asid; ins_vmid = vmid; ins_iova = iova;
    ins_gran_log2 = g; ins_level = lvl; ins_oa = oa; ins_s1_wr = w1; ins_s2_wr = w2;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  // one lookup; checks hit, address, fault, stage and latency
  task automatic lookup(input string tag, input logic [7:0] asid, input logic [7:0] vmid,
                        input logic [AW-1:0] iova, input logic wr, input logic [1:0] mode,
                        input logic [4:0] g1, input logic [4:0] g2,
                        input logic e_hit, input logic [AW-1:0] e_pa, input logic e_flt,
                        input logic e_s2, input int e_lat);
    int lat;
    @(negedge clk);
    check({tag, " ready"}, {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_asid = asid; req_vmid = vmid; req_iova = iova; req_write = wr;
    req_mode = mode; req_s1_gran_log2 = g1; req_s2_gran_log2 = g2;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (resp_valid) begin lat = k; break; end
    end
    if (e_hit) exp_hits++; else exp_misses++;
    check({tag, " latency"}, 64'(lat), 64'(e_lat));
    check({tag, " hit"}, {63'd0, resp_hit}, {63'd0, e_hit});
    check({tag, " paddr"}, 64'(resp_paddr), 64'(e_pa));
    check({tag, " fault"}, {63'd0, resp_fault}, {63'd0, e_flt});
    if (e_flt) check({tag, " fault stage"}, {63'd0, resp_fault_s2}, {63'd0, e_s2});
    @(negedge clk);
    check({tag, " single pulse"}, {63'd0, resp_valid}, 64'd0);
  endtask

  task automatic check_counts(input string tag);
    check({tag, " R9 hit_count"}, 64'(hit_count), 64'(exp_hits));
    check({tag, " R9 miss_count"}, 64'(miss_count), 64'(exp_misses));
  endtask

  task automatic t_reset();
    check("R12 reset resp_valid", {63'd0, resp_valid}, 64'd0);
    check("R12 reset ready", {63'd0, req_ready}, 64'd1);
    check_counts("reset");
  endtask

  task automatic t_basic();
    lookup("R9 empty miss", 8'd1, 8'd2, 40'h00_1234_5789, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    insert(8'd1, 8'd2, 40'h00_1234_5000, 5'd12, 2'd3, 40'h00_0ABC_DE00, 1'b1, 1'b1);
    lookup("R4 4K hit", 8'd1, 8'd2, 40'h00_1234_5789, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b1, 40'h00_0ABC_D789, 1'b0, 1'b0, 1);
    lookup("R2 asid mismatch", 8'd9, 8'd2, 40'h00_1234_5789, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R2 vmid mismatch", 8'd1, 8'd7, 40'h00_1234_5789, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R2 next page", 8'd1, 8'd2, 40'h00_1234_6000, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R1 granule mismatch", 8'd1, 8'd2, 40'h00_1234_5789, 1'b0, 2'b01, 5'd14, 5'd14,
           1'b0, '0, 1'b0, 1'b0, 1);
    check_counts("basic");
  endtask

  task automatic t_levels();
    // 4K level 2 block covers 2 MB (shift 21)
    insert(8'd1, 8'd2, 40'h00_1220_0000, 5'd12, 2'd2, 40'h00_4000_0000, 1'b1, 1'b1);
    lookup("R3 level2 only", 8'd1, 8'd2, 40'h00_1230_0ABC, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b1, 40'h00_4010_0ABC, 1'b0, 1'b0, 1);
    lookup("R3 level2 before level3", 8'd1, 8'd2, 40'h00_1234_5010, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b1, 40'h00_4014_5010, 1'b0, 1'b0, 1);
  endtask

  task automatic t_retry();
    insert(8'd3, 8'd4, 40'h05_0001_0000, 5'd16, 2'd3, 40'h07_7777_0000, 1'b1, 1'b1);
    lookup("R5 nested retry hit", 8'd3, 8'd4, 40'h05_0001_ABCD, 1'b0, 2'b11, 5'd12, 5'd16,
           1'b1, 40'h07_7777_ABCD, 1'b0, 1'b0, 2);
    lookup("R5 nested retry miss", 8'd3, 8'd4, 40'h05_0002_0000, 1'b0, 2'b11, 5'd12, 5'd16,
           1'b0, '0, 1'b0, 1'b0, 2);
    lookup("R6 stage1 mode no retry", 8'd3, 8'd4, 40'h05_0001_ABCD, 1'b0, 2'b01, 5'd12, 5'd16,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R6 stage2 mode no retry", 8'd3, 8'd4, 40'h05_0001_ABCD, 1'b0, 2'b10, 5'd12, 5'd16,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R6 equal granules no retry", 8'd3, 8'd4, 40'h05_0001_ABCD, 1'b0, 2'b11, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R1 64K code direct hit", 8'd3, 8'd4, 40'h05_0001_0004, 1'b0, 2'b11, 5'd16, 5'd12,
           1'b1, 40'h07_7777_0004, 1'b0, 1'b0, 1);
    check_counts("retry");
  endtask

  task automatic t_perm();
    insert(8'd5, 8'd1, 40'h00_0000_1000, 5'd12, 2'd3, 40'h00_0009_0000, 1'b0, 1'b1);
    insert(8'd6, 8'd1, 40'h00_0000_1000, 5'd12, 2'd3, 40'h00_000A_0000, 1'b1, 1'b0);
    insert(8'd7, 8'd1, 40'h00_0000_1000, 5'd12, 2'd3, 40'h00_000B_0000, 1'b1, 1'b1);
    lookup("R8 s1 denies write", 8'd5, 8'd1, 40'h00_0000_1010, 1'b1, 2'b11, 5'd12, 5'd12,
           1'b1, '0, 1'b1, 1'b0, 1);
    lookup("R7 read never faults", 8'd5, 8'd1, 40'h00_0000_1010, 1'b0, 2'b11, 5'd12, 5'd12,
           1'b1, 40'h00_0009_0010, 1'b0, 1'b0, 1);
    lookup("R8 s2 denies write", 8'd6, 8'd1, 40'h00_0000_1020, 1'b1, 2'b11, 5'd12, 5'd12,
           1'b1, '0, 1'b1, 1'b1, 1);
    lookup("R7 both allow write", 8'd7, 8'd1, 40'h00_0000_1030, 1'b1, 2'b11, 5'd12, 5'd12,
           1'b1, 40'h00_000B_0030, 1'b0, 1'b0, 1);
    check_counts("perm faulted hits");
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    ins_valid = 1'b1; ins_asid = 8'd1; ins_vmid = 8'd2; ins_iova = 40'h00_1234_5000;
    ins_gran_log2 = 5'd12; ins_level = 2'd3; ins_oa = 40'h0;
    @(negedge clk);
    flush = 1'b0; ins_valid = 1'b0;
    lookup("R10 flushed entry", 8'd1, 8'd2, 40'h00_1234_5789, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R10 flushed 64K", 8'd3, 8'd4, 40'h05_0001_ABCD, 1'b0, 2'b11, 5'd12, 5'd16,
           1'b0, '0, 1'b0, 1'b0, 2);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 8; i++)
      insert(8'(10 + i), 8'd0, 40'h00_0020_0000, 5'd12, 2'd3, 40'(32'h0010_0000 * (i + 1)), 1'b1, 1'b1);
    insert(8'd20, 8'd0, 40'h00_0020_0000, 5'd12, 2'd3, 40'h00_0F00_0000, 1'b1, 1'b1);
    lookup("R11 slot0 replaced", 8'd10, 8'd0, 40'h00_0020_0004, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R11 slot1 kept", 8'd11, 8'd0, 40'h00_0020_0004, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b1, 40'h00_0020_0004, 1'b0, 1'b0, 1);
    lookup("R11 new entry", 8'd20, 8'd0, 40'h00_0020_0004, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b1, 40'h00_0F00_0004, 1'b0, 1'b0, 1);
    insert(8'd21, 8'd0, 40'h00_0020_0000, 5'd12, 2'd3, 40'h00_0E00_0000, 1'b1, 1'b1);
    lookup("R11 slot1 replaced next", 8'd11, 8'd0, 40'h00_0020_0004, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b0, '0, 1'b0, 1'b0, 1);
    lookup("R11 slot2 kept", 8'd12, 8'd0, 40'h00_0020_0004, 1'b0, 2'b01, 5'd12, 5'd12,
           1'b1, 40'h00_0030_0004, 1'b0, 1'b0, 1);
    check_counts("final");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_levels();
    t_retry();
    t_perm();
    t_flush();
    t_replace();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule